// File: doc/BRIEF.md
# Timer Compare Interrupt Flag and Enable Controller

This block gathers the compare-match events of six 16-bit timers and turns them into one CPU interrupt request with a priority level. Each timer raises two kinds of event, compare A and compare B. Each event source has a sticky factor flag and an enable bit. Each timer also has a 3-bit priority. Software reaches the flags, enables, priorities and the live counter values through byte-wide registers on a simple single-cycle bus. Two timers share each byte. The live counter values come in on an input bus from the timers.

A mode input selects how writes to the flag bytes behave. In clear-only mode a written 1 clears a flag and a written 0 leaves it alone. In direct mode the written bit becomes the new flag value. The request output is driven from the flag, enable and priority state. The level output is the highest priority among the timers that have an enabled pending source. The level stays 0 when no timer is pending.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: A compare event pulse on `cmp_a_evt[i]` or `cmp_b_evt[i]` sets that source's flag at the next rising clock edge, whatever the value of its enable bit.
- R2: With `flag_rw_mode`=0, writing a flag byte clears each flag whose bit is written as 1 and leaves each flag whose bit is written as 0 unchanged.
- R3: With `flag_rw_mode`=1, writing a flag byte loads each flag with its written bit, so a 1 sets the flag and a 0 clears it.
- R4: When a compare event and a software clear reach the same flag in the same cycle, the flag ends up set.
- R5: Register map. The flag byte of timer pair k is at address k, the enable byte at 4+k, and the priority byte at 8+k, for k = 0..2. Pair k holds timers 2k (the lower timer) and 2k+1 (the upper timer). In the flag and enable bytes, the lower timer uses bit 2 for compare B and bit 3 for compare A, and the upper timer uses bit 6 for compare B and bit 7 for compare A.
- R6: Enable bits read back the value last written, where 1 enables the source. All enable bits are 0 after reset.
- R7: The priority byte holds the lower timer's level (0 to 7) in bits 2:0 and the upper timer's level in bits 6:4. Both fields read back as written. They have no reset value.
- R8: `irq_req` is 1 exactly when some timer with a nonzero priority has a source whose flag and enable are both 1. A pending timer with priority 0 never raises the request.
- R9: `irq_level` equals the highest priority among the timers that have an enabled pending source, and is 0 when there is none.
- R10: Timer i's live counter reads as its low byte at address 16+2i and its high byte at 17+2i. Writes to these addresses change nothing.
- R11: Unused bits (flag and enable bits 0, 1, 4, 5; priority bits 3, 7) and every unmapped address read as 0, and writes to them have no effect.
- R12: All flags are 0 after reset, and `irq_req` and `irq_level` are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_rw_mode | input | 1 | 0: clear-only flag writes, 1: direct flag writes |
| cmp_a_evt | input | 6 | Compare A event pulses, one per timer |
| cmp_b_evt | input | 6 | Compare B event pulses, one per timer |
| tmr_count | input | 96 | Live 16-bit counter values, timer i in bits 16i+15:16i |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Write strobe, registered at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Priority level of the request |

## Verification
Each compare event and bus write takes effect at the first rising edge after it is driven. The flag and enable readback, `irq_req` and `irq_level` are therefore due one cycle later. They come straight from the registers through combinational logic. Counter readback depends only on `bus_addr` and `tmr_count` and is valid in the same cycle. The bench drives inputs on the falling edge, lets one rising edge pass, and samples the outputs on the next falling edge. For reads it changes `bus_addr` with the write strobe low and samples 1 ns later, before any clock edge.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int FLG_BASE = 0;
  localparam int EN_BASE  = 4;
  localparam int PRI_BASE = 8;
  localparam int CNT_BASE = 16;

  // Flag value after a software write, for either write mode.
  function automatic logic flag_after_write(logic rw_mode, logic cur, logic wbit);
    if (rw_mode) return wbit;
    return wbit ? 1'b0 : cur;
  endfunction

  // A source is pending when its flag and enable are both set.
  function automatic logic src_pending(logic flag, logic en);
    return flag & en;
  endfunction

  // Bit position of a source in a shared byte: half 0/1, src 0=B 1=A.
  function automatic int src_bit(int half, int src);
    return 2 + src + 4 * half;
  endfunction

  function automatic int lvl_lsb(int half);
    return 4 * half;
  endfunction
endpackage

// File: rtl/tmr_src_cell.sv
module tmr_src_cell
  import tmr_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rw_mode,
  input  logic hw_set,
  input  logic sw_wr,
  input  logic sw_bit,
  input  logic en_wr,
  input  logic en_bit,
  output logic flag,
  output logic enable,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (hw_set) begin
      flag <= 1'b1;
    end else if (sw_wr) begin
      flag <= flag_after_write(rw_mode, flag, sw_bit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
    end else if (en_wr) begin
      enable <= en_bit;
    end
  end

  assign pending = src_pending(flag, enable);

  p_hw_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag);
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set && sw_wr) |=> flag);
  p_clear_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw_mode && sw_wr && sw_bit && !hw_set) |=> !flag);
  p_keep_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw_mode && sw_wr && !sw_bit && !hw_set) |=> (flag == $past(flag)));
  p_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_mode && sw_wr && !hw_set) |=> (flag == $past(sw_bit)));
  p_enable_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (enable == $past(en_bit)));
endmodule

// File: rtl/tmr_level_arb.sv
module tmr_level_arb #(
  parameter int NUM_TIMERS = 6,
  parameter int LVL_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_TIMERS-1:0] tmr_pend,
  input  logic [LVL_W-1:0]      tmr_lvl [NUM_TIMERS],
  output logic                  irq_req,
  output logic [LVL_W-1:0]      irq_level
);
  logic [LVL_W-1:0] best;

  always_comb begin
    best = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (tmr_pend[i] && (tmr_lvl[i] > best)) best = tmr_lvl[i];
    end
  end

  assign irq_level = best;
  assign irq_req   = |best;

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_bound
    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_pend[g] |-> (irq_level >= tmr_lvl[g]));
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int NUM_TIMERS = 6,
  parameter int CNT_W      = 16,
  parameter int LVL_W      = 3,
  parameter int ADDR_W     = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flag_rw_mode,
  input  logic [NUM_TIMERS-1:0]       cmp_a_evt,
  input  logic [NUM_TIMERS-1:0]       cmp_b_evt,
  input  logic [NUM_TIMERS*CNT_W-1:0] tmr_count,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [7:0]                  bus_wdata,
  output logic [7:0]                  bus_rdata,
  output logic                        irq_req,
  output logic [LVL_W-1:0]            irq_level
);
  localparam int CNT_BYTES = CNT_W / 8;

  logic [NUM_TIMERS-1:0] flag_a, flag_b, en_a, en_b, pend_a, pend_b, tmr_pend;
  logic [LVL_W-1:0]      prio_q [NUM_TIMERS];

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    localparam int P = t / 2;
    localparam int H = t % 2;
    localparam int BB = src_bit(H, 0);
    localparam int BA = src_bit(H, 1);
    localparam int LL = lvl_lsb(H);

    logic flg_sel, en_sel, pri_sel;
    assign flg_sel = bus_wr && (bus_addr == ADDR_W'(FLG_BASE + P));
    assign en_sel  = bus_wr && (bus_addr == ADDR_W'(EN_BASE + P));
    assign pri_sel = bus_wr && (bus_addr == ADDR_W'(PRI_BASE + P));

    tmr_src_cell u_src_a (
      .clk(clk), .rst_n(rst_n), .rw_mode(flag_rw_mode),
      .hw_set(cmp_a_evt[t]), .sw_wr(flg_sel), .sw_bit(bus_wdata[BA]),
      .en_wr(en_sel), .en_bit(bus_wdata[BA]),
      .flag(flag_a[t]), .enable(en_a[t]), .pending(pend_a[t])
    );

    tmr_src_cell u_src_b (
      .clk(clk), .rst_n(rst_n), .rw_mode(flag_rw_mode),
      .hw_set(cmp_b_evt[t]), .sw_wr(flg_sel), .sw_bit(bus_wdata[BB]),
      .en_wr(en_sel), .en_bit(bus_wdata[BB]),
      .flag(flag_b[t]), .enable(en_b[t]), .pending(pend_b[t])
    );

    // Priority fields carry no reset value; software programs them.
    always_ff @(posedge clk) begin
      if (pri_sel) prio_q[t] <= bus_wdata[LL +: LVL_W];
    end

    assign tmr_pend[t] = pend_a[t] | pend_b[t];
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (bus_addr == ADDR_W'(FLG_BASE + i / 2)) begin
        bus_rdata[src_bit(i % 2, 0)] = flag_b[i];
        bus_rdata[src_bit(i % 2, 1)] = flag_a[i];
      end
      if (bus_addr == ADDR_W'(EN_BASE + i / 2)) begin
        bus_rdata[src_bit(i % 2, 0)] = en_b[i];
        bus_rdata[src_bit(i % 2, 1)] = en_a[i];
      end
      if (bus_addr == ADDR_W'(PRI_BASE + i / 2)) begin
        bus_rdata[lvl_lsb(i % 2) +: LVL_W] = prio_q[i];
      end
      for (int b = 0; b < CNT_BYTES; b++) begin
        if (bus_addr == ADDR_W'(CNT_BASE + CNT_BYTES * i + b)) begin
          bus_rdata = tmr_count[i*CNT_W + 8*b +: 8];
        end
      end
    end
  end

  tmr_level_arb #(.NUM_TIMERS(NUM_TIMERS), .LVL_W(LVL_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .tmr_pend(tmr_pend), .tmr_lvl(prio_q),
    .irq_req(irq_req), .irq_level(irq_level)
  );

  p_req_needs_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (|tmr_pend));
  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|tmr_pend) |-> (irq_level == '0));
  p_unused_flag_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < ADDR_W'(EN_BASE)) |-> (bus_rdata[1:0] == 2'b00 && bus_rdata[5:4] == 2'b00));
endmodule

// File: tb/tb_tmr_irq_ctrl.sv
`timescale 1ns/1ps
module tb_tmr_irq_ctrl;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flag_rw_mode = 1'b0;
  logic [N-1:0] cmp_a_evt = '0, cmp_b_evt = '0;
  logic [N*16-1:0] tmr_count = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_req;
  logic [2:0]  irq_level;

  int checks = 0, errors = 0;
  bit done = 0;

  logic mflag [N][2];   // [t][0]=B, [t][1]=A
  logic men   [N][2];
  logic [2:0] mprio [N];

  always #4 clk = ~clk;

  tmr_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .flag_rw_mode(flag_rw_mode),
    .cmp_a_evt(cmp_a_evt), .cmp_b_evt(cmp_b_evt), .tmr_count(tmr_count),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_level(irq_level)
  );

  function automatic int bpos(int t, int s);
    return (t % 2 == 0) ? (s ? 3 : 2) : (s ? 7 : 6);
  endfunction

  function automatic logic [7:0] exp_read(logic [4:0] a);
    logic [7:0] v = '0;
    for (int t = 0; t < N; t++) begin
      for (int s = 0; s < 2; s++) begin
        if (int'(a) == t / 2)     v[bpos(t, s)] = mflag[t][s];
        if (int'(a) == 4 + t / 2) v[bpos(t, s)] = men[t][s];
      end
      if (int'(a) == 8 + t / 2) begin
        if (t % 2 == 0) v[2:0] = mprio[t]; else v[6:4] = mprio[t];
      end
      if (int'(a) == 16 + 2 * t) v = tmr_count[16*t +: 8];
      if (int'(a) == 17 + 2 * t) v = tmr_count[16*t + 8 +: 8];
    end
    return v;
  endfunction

  function automatic logic [2:0] exp_level();
    logic [2:0] m = 3'd0;
    for (int t = 0; t < N; t++)
      if (((mflag[t][0] && men[t][0]) || (mflag[t][1] && men[t][1])) && mprio[t] > m)
        m = mprio[t];
    return m;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_step(logic [N-1:0] ea, logic [N-1:0] eb, logic w, logic [4:0] a, logic [7:0] d);
    for (int t = 0; t < N; t++) begin
      for (int s = 0; s < 2; s++) begin
        logic ev = s ? ea[t] : eb[t];
        int p = bpos(t, s);
        if (ev) mflag[t][s] = 1'b1;
        else if (w && int'(a) == t / 2)
          mflag[t][s] = flag_rw_mode ? d[p] : (d[p] ? 1'b0 : mflag[t][s]);
        if (w && int'(a) == 4 + t / 2) men[t][s] = d[p];
      end
      if (w && int'(a) == 8 + t / 2) mprio[t] = (t % 2 == 0) ? d[2:0] : d[6:4];
    end
  endtask

  // Drive on a falling edge, one rising edge applies it, check at next falling edge.
  task automatic cyc(string tag, logic [N-1:0] ea, logic [N-1:0] eb, logic w, logic [4:0] a, logic [7:0] d);
    cmp_a_evt = ea; cmp_b_evt = eb; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_step(ea, eb, w, a, d);
    @(negedge clk);
    cmp_a_evt = '0; cmp_b_evt = '0; bus_wr = 1'b0;
    chk({tag, " R8 irq_req"}, irq_req, exp_level() != 3'd0);
    chk({tag, " R9 irq_level"}, irq_level, exp_level());
  endtask

  task automatic rd(string tag, logic [4:0] a);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp_read(a));
  endtask

  initial begin
    for (int t = 0; t < N; t++) begin
      mflag[t][0] = 0; mflag[t][1] = 0; men[t][0] = 0; men[t][1] = 0; mprio[t] = 0;
    end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 / R6 reset state
    chk("R12 irq_req after reset", irq_req, 1'b0);
    for (int a = 0; a < 3; a++) begin
      rd("R12 flags after reset", 5'(a));
      rd("R6 enables after reset", 5'(4 + a));
    end
    // R7 priority programming, R11 unused priority bits
    cyc("R7 prio all ones", '0, '0, 1'b1, 5'd8, 8'hFF);
    rd("R11 prio unused bits", 5'd8);
    chk("R11 prio literal", bus_rdata, 8'h77);
    cyc("R7 prio p0", '0, '0, 1'b1, 5'd8, 8'h21);
    cyc("R7 prio p1", '0, '0, 1'b1, 5'd9, 8'h43);
    cyc("R7 prio p2", '0, '0, 1'b1, 5'd10, 8'h65);
    for (int a = 8; a < 11; a++) rd("R7 prio readback", 5'(a));
    // R1 event with enable off
    cyc("R1 event no enable", 6'b000001, '0, 1'b0, 5'd0, 8'h00);
    rd("R1 R5 flag A timer0 bit3", 5'd0);
    chk("R5 flag literal", bus_rdata, 8'h08);
    // R6 enables, R11 unused enable bits
    cyc("R6 enable write", '0, '0, 1'b1, 5'd4, 8'hFF);
    rd("R6 R11 enable readback", 5'd4);
    chk("R11 enable literal", bus_rdata, 8'hCC);
    // R2 clear-only
    cyc("R2 write zero", '0, '0, 1'b1, 5'd0, 8'h00);
    rd("R2 zero keeps flag", 5'd0);
    cyc("R2 write one", '0, '0, 1'b1, 5'd0, 8'h08);
    rd("R2 one clears flag", 5'd0);
    // R4 set beats clear, timer1 compare B bit6
    cyc("R4 set", '0, 6'b000010, 1'b0, 5'd0, 8'h00);
    cyc("R4 set vs clear", '0, 6'b000010, 1'b1, 5'd0, 8'h40);
    rd("R4 flag stays", 5'd0);
    chk("R4 literal", bus_rdata, 8'h40);
    // R3 direct mode
    flag_rw_mode = 1'b1;
    cyc("R3 direct set", '0, '0, 1'b1, 5'd0, 8'h88);
    rd("R3 direct readback", 5'd0);
    cyc("R3 direct clear", '0, '0, 1'b1, 5'd0, 8'h00);
    rd("R3 direct cleared", 5'd0);
    flag_rw_mode = 1'b0;
    // R9 highest level
    cyc("R9 en p1", '0, '0, 1'b1, 5'd5, 8'hCC);
    cyc("R9 en p2", '0, '0, 1'b1, 5'd6, 8'hCC);
    cyc("R9 two pending", 6'b010100, '0, 1'b0, 5'd0, 8'h00);
    chk("R9 level literal", irq_level, 3'd5);
    cyc("R9 clear top", '0, '0, 1'b1, 5'd2, 8'h08);
    chk("R9 level after clear", irq_level, 3'd3);
    // R8 priority zero never requests
    cyc("R8 prio zero", '0, '0, 1'b1, 5'd9, 8'h40);
    chk("R8 zero prio no req", irq_req, 1'b0);
    cyc("R8 restore", '0, '0, 1'b1, 5'd9, 8'h43);
    cyc("R8 clear", '0, '0, 1'b1, 5'd1, 8'hCC);
    // R10 counter reads, write ignored
    for (int t = 0; t < N; t++) tmr_count[16*t +: 16] = 16'($urandom);
    for (int a = 16; a < 28; a++) rd("R10 counter byte", 5'(a));
    cyc("R10 counter write", '0, '0, 1'b1, 5'd16, 8'hAA);
    rd("R10 counter after write", 5'd16);
    // R11 unmapped addresses
    cyc("R11 unmapped write", '0, '0, 1'b1, 5'd3, 8'hFF);
    rd("R11 unmapped 3", 5'd3);
    rd("R11 unmapped 12", 5'd12);
    rd("R11 unmapped 31", 5'd31);
    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] ea = 6'($urandom) & 6'($urandom) & 6'($urandom);
      logic [N-1:0] eb = 6'($urandom) & 6'($urandom) & 6'($urandom);
      logic w = ($urandom % 2) == 0;
      logic [4:0] a = 5'($urandom % 12);
      flag_rw_mode = ($urandom % 4) == 0;
      tmr_count = {3{32'($urandom)}};
      cyc("R1 R2 R3 random", ea, eb, w, a, 8'($urandom));
      rd("R5 R10 random read", 5'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule